// File: doc/BRIEF.md
# Integer ALU with Multiply/Divide Holding Registers

This block is the arithmetic core of an in-order pipeline's execute stage. A 4-bit operation code selects one of sixteen functions over two operands and a shift distance. Fourteen of these functions are purely combinational and drive the result in the same cycle. The other two, multiply and divide, deposit a double-width outcome into a pair of internal holding registers (upper and lower) on the rising clock edge. Two dedicated codes later read those registers back out.

Operands, shift distance and code are plain level inputs sampled every cycle, and the result is a plain output. There is no valid/ready exchange at either side, because the block accepts one operation per cycle and never stalls. Back-pressure is therefore not applicable. A consumer that cannot take a result simply does not use it. A caller that must not disturb the holding registers keeps the code away from multiply and divide.

Top module: `alu_hilo`

## Requirements
- R1: Code 0000 returns a+b and code 1110 returns a-b, both wrapping modulo 2^W.
- R2: Code 0001 returns a AND b, code 1001 returns a OR b, code 1111 returns a XOR b and code 1000 returns NOT(a OR b).
- R3: Code 0011 returns 1 when a equals b and 0 otherwise. Code 1011 returns 1 when a is less than b taken as two's-complement values and 0 otherwise. The value sits in bit 0 and all other bits are zero.
- R4: Code 0100 returns the low W/2 bits of b placed in the upper half, with the lower half zero.
- R5: Code 1010 shifts a left by shamt. Code 1101 shifts a right by shamt with zero fill. Code 1100 shifts a right by shamt, copying the sign bit into the vacated positions.
- R6: Code 0111 stores the signed 2W-bit product of a and b at the next rising edge, with the upper W bits in the upper register and the lower W bits in the lower register. While the code is 0111 or 0010, the result output is zero.
- R7: Code 0010 with nonzero b stores the signed quotient (truncated toward zero) in the lower register and the remainder (same sign as a) in the upper register at the next rising edge.
- R8: Code 0010 with b equal to zero leaves both registers unchanged.
- R9: Code 0101 returns the upper register and code 0110 returns the lower register. No code other than 0111 and 0010 changes either register.
- R10: An active-low reset clears both registers to zero at once and holds them at zero while it stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; holding registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_code | input | 4 | Operation select |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| shamt | input | log2(W) | Shift distance |
| result | output | W | Operation outcome |

## Verification
The bench uses an 8-bit configuration. Every dividend value is swept against sixteen divisor values chosen at the boundaries: zero, one, the largest positive value, the most negative value, minus one, and alternating patterns. This separates signed from unsigned handling in SLT, SRA, multiply and divide. The shift distance is derived from a XOR b, so every distance appears with many operands. Each multiply and divide is read back through both readback codes. A zero divisor directly follows a multiply, so any register corruption shows up as a mismatch with the product left by that multiply. A final readback after the stateless codes catches stray writes. A reset issued over a live product checks that clearing is immediate.

// File: rtl/alu_hilo_pkg.sv
`timescale 1ns/1ps
package alu_hilo_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'h0, OP_AND  = 4'h1, OP_DIV  = 4'h2, OP_EQ   = 4'h3,
    OP_LUI  = 4'h4, OP_MFHI = 4'h5, OP_MFLO = 4'h6, OP_MULT = 4'h7,
    OP_NOR  = 4'h8, OP_OR   = 4'h9, OP_SLL  = 4'hA, OP_SLT  = 4'hB,
    OP_SRA  = 4'hC, OP_SRL  = 4'hD, OP_SUB  = 4'hE, OP_XOR  = 4'hF
  } alu_op_e;
endpackage

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
// Stateless functions; zero for codes handled elsewhere.
module alu_logic_unit
  import alu_hilo_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W),
  localparam int HALF = W / 2
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   res
);
  always_comb begin
    res = '0;
    case (op)
      OP_ADD: res = a + b;
      OP_SUB: res = a - b;
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_NOR: res = ~(a | b);
      OP_EQ:  res = {{(W-1){1'b0}}, (a == b)};
      OP_SLT: res = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      OP_LUI: res = {b[HALF-1:0], {HALF{1'b0}}};
      OP_SLL: res = a << shamt;
      OP_SRL: res = a >> shamt;
      OP_SRA: res = W'($signed(a) >>> shamt);
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_muldiv.sv
`timescale 1ns/1ps
// Single-cycle signed multiply and divide datapath.
module alu_muldiv #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         div_zero
);
  logic signed [2*W-1:0] prod;
  logic        [W-1:0]   divisor;

  assign prod     = $signed(a) * $signed(b);
  assign prod_hi  = prod[2*W-1:W];
  assign prod_lo  = prod[W-1:0];
  assign div_zero = (b == '0);
  // Substitute one so the divider never sees zero; result discarded.
  assign divisor  = div_zero ? {{(W-1){1'b0}}, 1'b1} : b;
  assign quo      = W'($signed(a) / $signed(divisor));
  assign rem      = W'($signed(a) % $signed(divisor));
endmodule

// File: rtl/alu_hilo_regs.sv
`timescale 1ns/1ps
module alu_hilo_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] hi_d,
  input  logic [W-1:0] lo_d,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end
endmodule

// File: rtl/alu_hilo.sv
`timescale 1ns/1ps
module alu_hilo
  import alu_hilo_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     op_code,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   result
);
  alu_op_e      op;
  logic [W-1:0] logic_res, prod_hi, prod_lo, quo, rem;
  logic [W-1:0] hi_d, lo_d, hi_val, lo_val;
  logic         div_zero, wr_en;

  assign op = alu_op_e'(op_code);

  alu_logic_unit #(.W(W)) u_logic (
    .op(op), .a(op_a), .b(op_b), .shamt(shamt), .res(logic_res)
  );

  alu_muldiv #(.W(W)) u_muldiv (
    .a(op_a), .b(op_b), .prod_hi(prod_hi), .prod_lo(prod_lo),
    .quo(quo), .rem(rem), .div_zero(div_zero)
  );

  always_comb begin
    wr_en = 1'b0;
    hi_d  = prod_hi;
    lo_d  = prod_lo;
    case (op)
      OP_MULT: wr_en = 1'b1;
      OP_DIV: begin
        wr_en = !div_zero;
        hi_d  = rem;
        lo_d  = quo;
      end
      default: wr_en = 1'b0;
    endcase
  end

  alu_hilo_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .hi_d(hi_d), .lo_d(lo_d), .hi_q(hi_val), .lo_q(lo_val)
  );

  always_comb begin
    case (op)
      OP_MFHI: result = hi_val;
      OP_MFLO: result = lo_val;
      default: result = logic_res;
    endcase
  end
endmodule

// File: rtl/alu_hilo_chk.sv
`timescale 1ns/1ps
module alu_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_code,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] result,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  logic signed [2*W-1:0] ref_prod;
  logic        [W-1:0]   ref_quo;
  logic                  is_mul, is_div, b_zero;

  assign ref_prod = $signed(op_a) * $signed(op_b);
  assign b_zero   = (op_b == '0);
  assign ref_quo  = b_zero ? '0 : W'($signed(op_a) / $signed(op_b));
  assign is_mul   = (op_code == 4'h7);
  assign is_div   = (op_code == 4'h2);

  assert_eq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'h3) |-> (result == {{(W-1){1'b0}}, (op_a == op_b)}));

  assert_mult_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_mul |=> ({hi, lo} == $past(ref_prod)));

  assert_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_div && !b_zero) |=> (lo == $past(ref_quo)));

  assert_divzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_div && b_zero) |=> ($stable(hi) && $stable(lo)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_mul && !is_div) |=> ($stable(hi) && $stable(lo)));

  assert_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hi == '0 && lo == '0));
endmodule

bind alu_hilo alu_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_a(op_a), .op_b(op_b),
  .result(result), .hi(hi_val), .lo(lo_val)
);

// File: tb/tb_alu_hilo.sv
`timescale 1ns/1ps
module tb_alu_hilo;
  localparam int W = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_code = 4'h5;
  logic [7:0] op_a = '0, op_b = '0;
  logic [2:0] shamt = '0;
  logic [7:0] result;

  int  n_vec = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [7:0] exp_hi = '0, exp_lo = '0;

  always #2.5 clk = ~clk;

  alu_hilo #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_a(op_a),
    .op_b(op_b), .shamt(shamt), .result(result)
  );

  function automatic int sx(logic [7:0] v);
    return {{24{v[7]}}, v};
  endfunction

  task automatic chk(string req, logic [7:0] exp);
    n_vec++;
    if (result !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h a=%h b=%h s=%0d: got %h expected %h",
               req, op_code, op_a, op_b, shamt, result, exp);
    end
  endtask

  task automatic apply(logic [3:0] o);
    @(negedge clk);
    op_code = o;
    #1;
  endtask

  logic [7:0] bvals [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h08,
                             8'h0F, 8'h10, 8'h55, 8'h7F, 8'h80, 8'h81,
                             8'hAA, 8'hF0, 8'hFE, 8'hFF};

  initial begin
    #1;
    chk("R10 reset upper", 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    apply(4'h5); chk("R10 upper after reset", 8'h00);
    apply(4'h6); chk("R10 lower after reset", 8'h00);

    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 16; j++) begin
        int p, q, r, sa, sb;
        op_a  = 8'(i);
        op_b  = bvals[j];
        shamt = 3'(op_a ^ op_b);
        sa = sx(op_a);
        sb = sx(op_b);
        p  = sa * sb;
        apply(4'h7); chk("R6 result zero on multiply", 8'h00);
        exp_hi = p[15:8];
        exp_lo = p[7:0];
        apply(4'h5); chk("R6 product upper", exp_hi);
        apply(4'h6); chk("R6 product lower", exp_lo);
        apply(4'h2); chk("R6 result zero on divide", 8'h00);
        if (sb != 0) begin
          q = sa / sb;
          r = sa % sb;
          exp_hi = r[7:0];
          exp_lo = q[7:0];
          apply(4'h5); chk("R7 remainder", exp_hi);
          apply(4'h6); chk("R7 quotient", exp_lo);
        end else begin
          apply(4'h5); chk("R8 upper kept on zero divisor", exp_hi);
          apply(4'h6); chk("R8 lower kept on zero divisor", exp_lo);
        end
        apply(4'h0); chk("R1 add", 8'(i + op_b));
        apply(4'hE); chk("R1 sub", 8'(i - op_b));
        apply(4'h1); chk("R2 and", op_a & op_b);
        apply(4'h9); chk("R2 or", op_a | op_b);
        apply(4'hF); chk("R2 xor", op_a ^ op_b);
        apply(4'h8); chk("R2 nor", ~(op_a | op_b));
        apply(4'h3); chk("R3 equal", (op_a == op_b) ? 8'h01 : 8'h00);
        apply(4'hB); chk("R3 signed less", (sa < sb) ? 8'h01 : 8'h00);
        apply(4'h4); chk("R4 upper immediate", {op_b[3:0], 4'h0});
        apply(4'hA); chk("R5 shift left", 8'(op_a << shamt));
        apply(4'hD); chk("R5 shift right logical", op_a >> shamt);
        apply(4'hC); chk("R5 shift right arithmetic", 8'(sa >>> shamt));
        apply(4'h6); chk("R9 lower untouched by stateless codes", exp_lo);
      end
    end

    op_a = 8'h03; op_b = 8'h05;
    apply(4'h7);
    apply(4'h6); chk("R9 lower readback before reset", 8'h0F);
    rst_n = 1'b0;
    #1; chk("R10 reset clears at once", 8'h00);
    @(negedge clk); rst_n = 1'b1;
    apply(4'h5); chk("R10 upper cleared", 8'h00);
    apply(4'h6); chk("R10 lower cleared", 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule